// File: doc/BRIEF.md
# Wake Event Status Controller

This block collects wake events from twelve general-purpose input lines and drives an active-low power-management event output. It sits on the standby rail. Each input passes through a synchroniser, and a rising edge on the synchronised signal latches a per-source sticky status bit. These bits latch whether or not any enable is set. A global status bit is raised while any latched source is also enabled by the matching bit of the per-source enable vector. The event output is driven low while both the global status and a global enable bit are set.

Software reaches the block through a byte-wide register port with a 4-bit offset, write data, a write strobe, a read strobe and a registered read-data bus. Every status bit is cleared only by writing a one to it. The standby-rail power-on reset is the only reset that clears the block's state. The main-rail power-on reset, soft reset and hard reset inputs are accepted and ignored.

Top module: `wake_status_ctrl`

## Requirements
- R1: While `stby_por_n` is low, all four registers are 0x00 and `pme_n` is 1.
- R2: A wake event is a rising edge of a source input seen after the synchroniser. A source held high raises no further event after its bit has been cleared.
- R3: A source status bit is set by its wake event regardless of `src_en` and of the global enable.
- R4: Writing to offset 0x08 or 0x09 clears each status bit whose write-data bit is 1 and leaves the bits written 0 unchanged. An event that coincides with a clear of the same bit leaves that bit set.
- R5: The global status bit (offset 0x00, bit 0) is set on the clock after any source status bit is 1 while its `src_en` bit is 1. This happens even when the global enable is 0.
- R6: Writing 1 to offset 0x00 bit 0 clears the global status bit, provided no enabled source status bit is still set. Writing 0 leaves it unchanged.
- R7: `pme_n` is 0 exactly when the global status bit and the global enable bit are both 1. Otherwise it is 1.
- R8: Reads return the global status in offset 0x00 bit 0 and the global enable in offset 0x04 bit 0. Offset 0x08 bits 3:0 carry the status of sources 11:8, and offset 0x09 bits 7:0 carry the status of sources 7:0. Every other offset, and every reserved bit, reads 0.
- R9: Pulsing `main_por_n`, `soft_rst` or `hard_rst` changes no register and does not change `pme_n`.
- R10: `reg_rdata` updates on the clock edge that samples `reg_rd` high and holds its value while `reg_rd` is low.
- R11: Offset 0x04 bit 0 is written from write-data bit 0. Write-data bits 7:1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Standby-domain clock |
| stby_por_n | input | 1 | Standby-rail power-on reset, active low, asynchronous |
| main_por_n | input | 1 | Main-rail power-on reset, active low, ignored |
| soft_rst | input | 1 | Soft reset, ignored |
| hard_rst | input | 1 | Hard reset, ignored |
| src_in | input | 12 | Raw wake source inputs, asynchronous |
| src_en | input | 12 | Per-source enables feeding the global status |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 8 | Registered read data |
| pme_n | output | 1 | Power-management event, active low |

## Verification
The bound checker checks a set of properties on every clock. A detected edge always leaves its status bit set on the next cycle. Status bits never fall without a write, and a zero write never clears anything. An enabled pending source always raises the global status. The output is low only while the enable is set, and the read bus holds its value between reads. Some behaviour can only be shown by the bench's directed scenarios. These are the exact register map and its zero offsets, the same-cycle event-and-clear race, and the fact that a held-high input stays silent after a clear. They also cover the absence of any effect from the three ignored resets, and the full clear on the standby reset.

// File: rtl/wake_pkg.sv
package wake_pkg;
  localparam int ADDR_W = 4;
  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] ofs_t;

  // Offsets decoded by software; positions are part of the behaviour.
  localparam ofs_t OFS_GSTS = 4'h0;
  localparam ofs_t OFS_GEN  = 4'h4;
  localparam ofs_t OFS_HI   = 4'h8;
  localparam ofs_t OFS_LO   = 4'h9;

  // Sticky write-one-to-clear update: a set wins over a clear.
  function automatic byte_t w1c_next(byte_t cur, byte_t set, byte_t clr);
    return (cur & ~clr) | set;
  endfunction

  // Single flag with the same set-wins rule.
  function automatic logic flag_next(logic cur, logic set, logic clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/wake_edge_sync.sv
module wake_edge_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_in,
  output logic [W-1:0] rise_evt
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= raw_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= stage_q[STAGES-1];
  end

  assign rise_evt = stage_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/wake_sticky_bank.sv
module wake_sticky_bank
  import wake_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr_stb,
  input  byte_t        clr_data,
  output logic [W-1:0] sts
);
  byte_t cur_b, set_b, clr_b, nxt_b;

  always_comb begin
    cur_b = '0;
    set_b = '0;
    cur_b[W-1:0] = sts;
    set_b[W-1:0] = evt;
    clr_b = clr_stb ? clr_data : '0;
    nxt_b = w1c_next(cur_b, set_b, clr_b);
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts[i] <= 1'b0;
      else        sts[i] <= nxt_b[i];
    end
  end
endmodule

// File: rtl/wake_global_regs.sv
module wake_global_regs
  import wake_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic wr_sts,
  input  logic wr_en,
  input  logic wbit,
  output logic gsts_q,
  output logic gen_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gsts_q <= 1'b0;
      gen_q  <= 1'b0;
    end else begin
      gsts_q <= flag_next(gsts_q, set_req, wr_sts & wbit);
      if (wr_en) gen_q <= wbit;
    end
  end
endmodule

// File: rtl/wake_read_port.sv
module wake_read_port
  import wake_pkg::*;
#(
  parameter int NUM_HI = 4,
  parameter int NUM_LO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  ofs_t              addr,
  input  logic              gsts,
  input  logic              gen,
  input  logic [NUM_HI-1:0] hi_sts,
  input  logic [NUM_LO-1:0] lo_sts,
  output byte_t             rdata
);
  byte_t sel;

  always_comb begin
    sel = '0;
    unique case (addr)
      OFS_GSTS: sel[0] = gsts;
      OFS_GEN:  sel[0] = gen;
      OFS_HI:   sel[NUM_HI-1:0] = hi_sts;
      OFS_LO:   sel[NUM_LO-1:0] = lo_sts;
      default:  sel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (rd_stb) rdata <= sel;
  end
endmodule

// File: rtl/wake_status_ctrl.sv
module wake_status_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_LO      = 8,
  parameter int NUM_HI      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     stby_por_n,
  input  logic                     main_por_n,
  input  logic                     soft_rst,
  input  logic                     hard_rst,
  input  logic [NUM_LO+NUM_HI-1:0] src_in,
  input  logic [NUM_LO+NUM_HI-1:0] src_en,
  input  logic [3:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  input  logic                     reg_wr,
  input  logic                     reg_rd,
  output logic [7:0]               reg_rdata,
  output logic                     pme_n
);
  localparam int NUM_SRC = NUM_LO + NUM_HI;

  // Main-rail resets are accepted but deliberately have no path into state.
  logic unused_resets;
  assign unused_resets = main_por_n ^ soft_rst ^ hard_rst;

  logic [NUM_SRC-1:0] evt_all;
  logic [NUM_SRC-1:0] sticky_all;
  logic [NUM_LO-1:0]  sticky_lo;
  logic [NUM_HI-1:0]  sticky_hi;
  logic               wr_gsts, wr_gen, wr_hi, wr_lo;
  logic               gsts_set;
  logic               gsts_q, gen_q;

  assign wr_gsts = reg_wr && (reg_addr == OFS_GSTS);
  assign wr_gen  = reg_wr && (reg_addr == OFS_GEN);
  assign wr_hi   = reg_wr && (reg_addr == OFS_HI);
  assign wr_lo   = reg_wr && (reg_addr == OFS_LO);

  wake_edge_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (stby_por_n),
    .raw_in   (src_in),
    .rise_evt (evt_all)
  );

  wake_sticky_bank #(.W(NUM_LO)) u_lo (
    .clk      (clk),
    .rst_n    (stby_por_n),
    .evt      (evt_all[NUM_LO-1:0]),
    .clr_stb  (wr_lo),
    .clr_data (reg_wdata),
    .sts      (sticky_lo)
  );

  wake_sticky_bank #(.W(NUM_HI)) u_hi (
    .clk      (clk),
    .rst_n    (stby_por_n),
    .evt      (evt_all[NUM_SRC-1:NUM_LO]),
    .clr_stb  (wr_hi),
    .clr_data (reg_wdata),
    .sts      (sticky_hi)
  );

  assign sticky_all = {sticky_hi, sticky_lo};
  assign gsts_set   = |(sticky_all & src_en);

  wake_global_regs u_glob (
    .clk     (clk),
    .rst_n   (stby_por_n),
    .set_req (gsts_set),
    .wr_sts  (wr_gsts),
    .wr_en   (wr_gen),
    .wbit    (reg_wdata[0]),
    .gsts_q  (gsts_q),
    .gen_q   (gen_q)
  );

  wake_read_port #(.NUM_HI(NUM_HI), .NUM_LO(NUM_LO)) u_rd (
    .clk    (clk),
    .rst_n  (stby_por_n),
    .rd_stb (reg_rd),
    .addr   (reg_addr),
    .gsts   (gsts_q),
    .gen    (gen_q),
    .hi_sts (sticky_hi),
    .lo_sts (sticky_lo),
    .rdata  (reg_rdata)
  );

  assign pme_n = ~(gsts_q & gen_q);
endmodule

// File: rtl/wake_status_chk.sv
module wake_status_chk #(
  parameter int NUM_SRC = 12,
  parameter int NUM_LO  = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] evt_all,
  input logic [NUM_SRC-1:0] sticky_all,
  input logic [NUM_SRC-1:0] src_en,
  input logic               gsts_q,
  input logic               gen_q,
  input logic               pme_n,
  input logic               reg_wr,
  input logic               reg_rd,
  input logic [3:0]         reg_addr,
  input logic [7:0]         reg_wdata,
  input logic [7:0]         reg_rdata
);
  // R1
  always @(posedge clk) if (!rst_n) reset_idle_chk: assert (pme_n);

  // R2
  evt_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_all) |=> ((sticky_all & $past(evt_all)) == $past(evt_all)));

  // R4
  zero_write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 4'h9 && reg_wdata == 8'h00) |=>
      (($past(sticky_all[NUM_LO-1:0]) & ~sticky_all[NUM_LO-1:0]) == '0));

  // R4
  no_write_no_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> (($past(sticky_all) & ~sticky_all) == '0));

  // R5
  global_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sticky_all & src_en)) |=> gsts_q);

  // R7
  out_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pme_n |-> gen_q);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind wake_status_ctrl wake_status_chk #(.NUM_SRC(NUM_LO + NUM_HI), .NUM_LO(NUM_LO)) u_chk (
  .clk        (clk),
  .rst_n      (stby_por_n),
  .evt_all    (evt_all),
  .sticky_all (sticky_all),
  .src_en     (src_en),
  .gsts_q     (gsts_q),
  .gen_q      (gen_q),
  .pme_n      (pme_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata)
);

// File: tb/wake_status_ctrl_test.sv
module wake_status_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        stby_por_n = 1'b0;
  logic        main_por_n = 1'b1;
  logic        soft_rst = 1'b0;
  logic        hard_rst = 1'b0;
  logic [11:0] src_in = '0;
  logic [11:0] src_en = '0;
  logic [3:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_rdata;
  logic        pme_n;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_status_ctrl uut (
    .clk(clk), .stby_por_n(stby_por_n), .main_por_n(main_por_n),
    .soft_rst(soft_rst), .hard_rst(hard_rst), .src_in(src_in),
    .src_en(src_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .pme_n(pme_n)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(int idx);
    @(negedge clk);
    src_in[idx] = 1'b1;
    repeat (4) @(negedge clk);
    src_in[idx] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      rd(a[3:0], d);
      check("R1/R8 reset read", d, 8'h00);
    end
    check("R1 pme_n after reset", {7'b0, pme_n}, 8'h01);
  endtask

  task automatic t_capture_no_enable;
    logic [7:0] d;
    src_en = '0;
    pulse(3);
    pulse(9);
    rd(4'h9, d); check("R3 low bank capture", d, 8'h08);
    rd(4'h8, d); check("R3 high bank capture", d, 8'h02);
    rd(4'h0, d); check("R5 no enabled source", d, 8'h00);
    check("R7 idle output", {7'b0, pme_n}, 8'h01);
  endtask

  task automatic t_global;
    logic [7:0] d;
    src_en = 12'h008;
    repeat (2) @(negedge clk);
    rd(4'h0, d); check("R5 global set with enable 0", d, 8'h01);
    check("R7 output held by enable", {7'b0, pme_n}, 8'h01);
    wr(4'h4, 8'hFE);
    rd(4'h4, d); check("R11 upper bits ignored", d, 8'h00);
    wr(4'h4, 8'hFF);
    rd(4'h4, d); check("R11 enable readback", d, 8'h01);
    check("R7 output asserted", {7'b0, pme_n}, 8'h00);
    wr(4'h0, 8'h00);
    rd(4'h0, d); check("R6 zero write keeps", d, 8'h01);
    wr(4'h0, 8'h01);
    rd(4'h0, d); check("R6 re-set while source pending", d, 8'h01);
    wr(4'h9, 8'h08);
    wr(4'h0, 8'h01);
    rd(4'h0, d); check("R6 global cleared", d, 8'h00);
    check("R7 output released", {7'b0, pme_n}, 8'h01);
  endtask

  task automatic t_partial_clear;
    logic [7:0] d;
    src_en = '0;
    pulse(0);
    pulse(5);
    pulse(7);
    rd(4'h9, d); check("R2 several sources", d, 8'hA1);
    wr(4'h9, 8'h00);
    rd(4'h9, d); check("R4 zero write", d, 8'hA1);
    wr(4'h9, 8'h21);
    rd(4'h9, d); check("R4 partial clear", d, 8'h80);
    wr(4'h8, 8'hFF);
    rd(4'h8, d); check("R4 high bank clear", d, 8'h00);
    wr(4'h9, 8'hFF);
    rd(4'h9, d); check("R4 full clear", d, 8'h00);
  endtask

  task automatic t_race;
    logic [7:0] d;
    @(negedge clk);
    src_in[2] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 4'h9; reg_wdata = 8'h04; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    rd(4'h9, d); check("R4 event wins over clear", d, 8'h04);
    wr(4'h9, 8'h04);
    rd(4'h9, d); check("R2 held level no re-event", d, 8'h00);
    repeat (5) @(negedge clk);
    rd(4'h9, d); check("R2 still clear while high", d, 8'h00);
    src_in[2] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_ignored_resets;
    logic [7:0] d;
    src_en = 12'h800;
    pulse(11);
    pulse(1);
    repeat (2) @(negedge clk);
    check("R7 output low before resets", {7'b0, pme_n}, 8'h00);
    @(negedge clk); main_por_n = 1'b0; soft_rst = 1'b1; hard_rst = 1'b1;
    repeat (3) @(negedge clk);
    main_por_n = 1'b1; soft_rst = 1'b0; hard_rst = 1'b0;
    check("R9 output unchanged", {7'b0, pme_n}, 8'h00);
    rd(4'h8, d); check("R9 high bank kept", d, 8'h08);
    rd(4'h9, d); check("R9 low bank kept", d, 8'h02);
    rd(4'h0, d); check("R9 global kept", d, 8'h01);
    rd(4'h4, d); check("R9 enable kept", d, 8'h01);
    rd(4'h3, d); check("R8 gap offset", d, 8'h00);
    rd(4'h9, d);
    wr(4'h9, 8'h02);
    repeat (2) @(negedge clk);
    check("R10 rdata held", reg_rdata, 8'h02);
    @(negedge clk); stby_por_n = 1'b0;
    @(negedge clk);
    check("R1 output during standby reset", {7'b0, pme_n}, 8'h01);
    stby_por_n = 1'b1;
    src_en = '0;
    rd(4'h8, d); check("R1 high bank cleared", d, 8'h00);
    rd(4'h0, d); check("R1 global cleared", d, 8'h00);
    rd(4'h4, d); check("R1 enable cleared", d, 8'h00);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    stby_por_n = 1'b1;
    t_reset();
    t_capture_no_enable();
    t_global();
    t_partial_clear();
    t_race();
    t_ignored_resets();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule